// File: doc/BRIEF.md
# Per-Hart Cache Event Tally

This block keeps a bank of event counters for one level of cache, on behalf of one hart. The cache presents a lookup strobe each cycle it performs a lookup, tagged with the kind of access, the hart that made the request and the outcome. Separate strobes report line fills, writebacks, coherency snoops and outbound prefetches. Two vectors of per-miss pending flags, one for load misses and one for code-fetch misses, drive two cycle counters that measure how long the hart waits on a miss.

When the cache is shared (`SHARED` = 1), only traffic that belongs to hart `LOCAL_HART` is counted. Outbound prefetches are never counted in that case. Each counter is a free-running value that any reader may sample on the flat `evt_cnt` output. Several strobes may fire in the same cycle, and every counter they touch advances in that cycle.

Top module: `cache_event_tally`

## Requirements
- R1: After reset every counter reads zero. Counter k occupies `evt_cnt[CW*k +: CW]`.
- R2: A counted lookup advances its kind's ACCESS counter and exactly one of its HIT, MISS or MERGE counters. The kind codes are 0 data load, 1 prefetch read, 2 code fetch and 3 write. The result codes are 0 hit, 1 miss and 2 merge. The groups start at index 4 (load), 8 (prefetch), 12 (code) and 16 (write), with offsets +0 access, +1 hit, +2 miss and +3 merge. A lookup with result code 3 changes no counter.
- R3: The read group at index 0 (same offsets) counts kinds 0, 1 and 2 but not writes. The read-write group at index 20 counts all four kinds.
- R4: With `SHARED`=1, a lookup whose `lk_hart` differs from `LOCAL_HART` changes no counter.
- R5: Fill (index 26) and writeback (index 27) advance only when their hart tag equals `LOCAL_HART` (or when `SHARED`=0).
- R6: With `SHARED`=1, the outbound-prefetch counter (index 28) stays zero. With `SHARED`=0, it counts `opf_vld`.
- R7: A counted snoop advances the aggregate snoop group at index 29. It also advances the local-origin group at index 33 when `snp_remote`=0, or the remote-origin group at index 37 when `snp_remote`=1. Each group has offsets +0 access, +1 hit clean, +2 hit modified and +3 miss. The snoop result codes are 0 miss, 1 hit clean and 2 hit modified; code 3 and a non-local `snp_hart` in a shared cache are ignored.
- R8: The load-miss cycle counter (index 24) advances by exactly one in each cycle where any bit of `ld_miss_pend` is set, however many bits are set. The code-miss cycle counter (index 25) does the same for `code_miss_pend`.
- R9: Strobes of different kinds in one cycle each advance their own counters in that same cycle. Every counter value is visible one clock after the strobe.
- R10: Counters wrap modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | 1 | Lookup performed this cycle |
| lk_kind | input | 2 | Lookup kind code |
| lk_hart | input | HW | Hart that issued the lookup |
| lk_res | input | 2 | Lookup result code |
| fill_vld | input | 1 | Line fill completed |
| fill_hart | input | HW | Hart whose request caused the fill |
| wb_vld | input | 1 | Modified line written out |
| wb_hart | input | HW | Hart whose request caused the writeback |
| snp_vld | input | 1 | Snoop lookup performed |
| snp_hart | input | HW | Hart the snoop is attributed to |
| snp_remote | input | 1 | Snoop came from a remote hart |
| snp_res | input | 2 | Snoop result code |
| opf_vld | input | 1 | Outbound prefetch issued |
| ld_miss_pend | input | NSLOT | Per-slot load miss outstanding flags |
| code_miss_pend | input | NSLOT | Per-slot code-fetch miss outstanding flags |
| evt_cnt | output | NEV*CW | All counters, counter k at bits CW*k upward |

## Verification
A lookup miss and the miss-cycle accumulation can land in the same cycle. So can a lookup and a snoop, along with a fill and a writeback. The bench drives a load-kind miss lookup while `ld_miss_pend` already has two bits set. In that same cycle it raises fill, writeback, a remote dirty snoop and an outbound prefetch. The scoreboard then expects the following in the very next sample, each computed independently: the miss counter advances by one, the miss-cycle counter advances by one rather than two, both snoop groups advance, and the prefetch counter stays zero.

// File: rtl/cev_pkg.sv
package cev_pkg;
  localparam int NEV          = 41;
  localparam int E_RD         = 0;
  localparam int E_DATA       = 4;
  localparam int E_PREF       = 8;
  localparam int E_CODE       = 12;
  localparam int E_WR         = 16;
  localparam int E_RW         = 20;
  localparam int E_DATA_MCYC  = 24;
  localparam int E_CODE_MCYC  = 25;
  localparam int E_FILL       = 26;
  localparam int E_WB         = 27;
  localparam int E_OPREF      = 28;
  localparam int E_SNP        = 29;
  localparam int E_SNP_LOC    = 33;
  localparam int E_SNP_REM    = 37;

  typedef enum logic [1:0] {K_DATA = 2'd0, K_PREF = 2'd1, K_CODE = 2'd2, K_WR = 2'd3} kind_e;
  typedef enum logic [1:0] {R_HIT = 2'd0, R_MISS = 2'd1, R_MERGE = 2'd2, R_NONE = 2'd3} lres_e;
  typedef enum logic [1:0] {S_MISS = 2'd0, S_CLEAN = 2'd1, S_DIRTY = 2'd2, S_NONE = 2'd3} sres_e;

  // first counter of the group that belongs to a lookup kind
  function automatic int kind_base(input logic [1:0] k);
    return E_DATA + 4 * int'(k);
  endfunction

  // offset within a lookup group: +1 hit, +2 miss, +3 merge
  function automatic int lres_off(input logic [1:0] r);
    return 1 + int'(r);
  endfunction

  // offset within a snoop group: +1 clean, +2 dirty, +3 miss
  function automatic int sres_off(input logic [1:0] r);
    return (r == S_MISS) ? 3 : int'(r);
  endfunction
endpackage

// File: rtl/cev_classify.sv
module cev_classify
  import cev_pkg::*;
#(
  parameter int HW         = 2,
  parameter int LOCAL_HART = 1,
  parameter bit SHARED     = 1'b1
) (
  input  logic          lk_vld,
  input  logic [1:0]    lk_kind,
  input  logic [HW-1:0] lk_hart,
  input  logic [1:0]    lk_res,
  input  logic          fill_vld,
  input  logic [HW-1:0] fill_hart,
  input  logic          wb_vld,
  input  logic [HW-1:0] wb_hart,
  input  logic          snp_vld,
  input  logic [HW-1:0] snp_hart,
  input  logic          snp_remote,
  input  logic [1:0]    snp_res,
  input  logic          opf_vld,
  output logic          lookup_take,
  output logic          snoop_take,
  output logic [NEV-1:0] inc
);
  localparam logic [HW-1:0] MY_HART = HW'(LOCAL_HART);

  function automatic logic owned(input logic [HW-1:0] h);
    return !SHARED || (h == MY_HART);
  endfunction

  assign lookup_take = lk_vld && (lk_res != R_NONE) && owned(lk_hart);
  assign snoop_take  = snp_vld && (snp_res != S_NONE) && owned(snp_hart);

  always_comb begin
    int kb, ro, so, ob;
    inc = '0;
    kb = kind_base(lk_kind);
    ro = lres_off(lk_res);
    so = sres_off(snp_res);
    ob = snp_remote ? E_SNP_REM : E_SNP_LOC;
    if (lookup_take) begin
      inc[kb]        = 1'b1;
      inc[kb + ro]   = 1'b1;
      inc[E_RW]      = 1'b1;
      inc[E_RW + ro] = 1'b1;
      if (lk_kind != K_WR) begin
        inc[E_RD]      = 1'b1;
        inc[E_RD + ro] = 1'b1;
      end
    end
    if (fill_vld && owned(fill_hart)) inc[E_FILL] = 1'b1;
    if (wb_vld && owned(wb_hart))     inc[E_WB]   = 1'b1;
    if (opf_vld && !SHARED)           inc[E_OPREF] = 1'b1;
    if (snoop_take) begin
      inc[E_SNP]      = 1'b1;
      inc[E_SNP + so] = 1'b1;
      inc[ob]         = 1'b1;
      inc[ob + so]    = 1'b1;
    end
  end
endmodule

// File: rtl/cev_miss_track.sv
module cev_miss_track #(
  parameter int NSLOT = 4
) (
  input  logic [NSLOT-1:0] ld_miss_pend,
  input  logic [NSLOT-1:0] code_miss_pend,
  output logic             data_busy,
  output logic             code_busy
);
  // one cycle of waiting, whatever the overlap
  assign data_busy = |ld_miss_pend;
  assign code_busy = |code_miss_pend;
endmodule

// File: rtl/cev_counter_bank.sv
module cev_counter_bank #(
  parameter int N  = 41,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         inc,
  output logic [N-1:0][CW-1:0] cnt
);
  for (genvar i = 0; i < N; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[i] <= '0;
      else        cnt[i] <= cnt[i] + CW'(inc[i]);
    end
  end
endmodule

// File: rtl/cache_event_tally.sv
module cache_event_tally
  import cev_pkg::*;
#(
  parameter int HW         = 2,
  parameter int LOCAL_HART = 1,
  parameter bit SHARED     = 1'b1,
  parameter int NSLOT      = 4,
  parameter int CW         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [1:0]        lk_kind,
  input  logic [HW-1:0]     lk_hart,
  input  logic [1:0]        lk_res,
  input  logic              fill_vld,
  input  logic [HW-1:0]     fill_hart,
  input  logic              wb_vld,
  input  logic [HW-1:0]     wb_hart,
  input  logic              snp_vld,
  input  logic [HW-1:0]     snp_hart,
  input  logic              snp_remote,
  input  logic [1:0]        snp_res,
  input  logic              opf_vld,
  input  logic [NSLOT-1:0]  ld_miss_pend,
  input  logic [NSLOT-1:0]  code_miss_pend,
  output logic [NEV*CW-1:0] evt_cnt
);
  logic [NEV-1:0]         inc_evt;
  logic [NEV-1:0]         inc_all;
  logic [NEV-1:0][CW-1:0] cnt;
  logic                   lookup_take;
  logic                   snoop_take;
  logic                   data_busy;
  logic                   code_busy;

  cev_classify #(.HW(HW), .LOCAL_HART(LOCAL_HART), .SHARED(SHARED)) u_cls (
    .lk_vld(lk_vld), .lk_kind(lk_kind), .lk_hart(lk_hart), .lk_res(lk_res),
    .fill_vld(fill_vld), .fill_hart(fill_hart), .wb_vld(wb_vld), .wb_hart(wb_hart),
    .snp_vld(snp_vld), .snp_hart(snp_hart), .snp_remote(snp_remote), .snp_res(snp_res),
    .opf_vld(opf_vld), .lookup_take(lookup_take), .snoop_take(snoop_take), .inc(inc_evt)
  );

  cev_miss_track #(.NSLOT(NSLOT)) u_miss (
    .ld_miss_pend(ld_miss_pend), .code_miss_pend(code_miss_pend),
    .data_busy(data_busy), .code_busy(code_busy)
  );

  always_comb begin
    inc_all = inc_evt;
    inc_all[E_DATA_MCYC] = data_busy;
    inc_all[E_CODE_MCYC] = code_busy;
  end

  cev_counter_bank #(.N(NEV), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .inc(inc_all), .cnt(cnt)
  );

  assign evt_cnt = cnt;
endmodule

// File: rtl/cache_event_tally_chk.sv
module cache_event_tally_chk
  import cev_pkg::*;
#(
  parameter int HW         = 2,
  parameter int LOCAL_HART = 1,
  parameter bit SHARED     = 1'b1,
  parameter int NSLOT      = 4,
  parameter int CW         = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_vld,
  input logic [HW-1:0]     lk_hart,
  input logic [NSLOT-1:0]  ld_miss_pend,
  input logic [NEV*CW-1:0] evt_cnt
);
  function automatic logic [CW-1:0] sl(input logic [NEV*CW-1:0] v, input int i);
    return v[i*CW +: CW];
  endfunction

  for (genvar g = 0; g < 6; g++) begin : g_grp
    // R2
    acc_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sl(evt_cnt, 4*g) - $past(sl(evt_cnt, 4*g))) ==
      CW'((sl(evt_cnt, 4*g+1) - $past(sl(evt_cnt, 4*g+1))) +
          (sl(evt_cnt, 4*g+2) - $past(sl(evt_cnt, 4*g+2))) +
          (sl(evt_cnt, 4*g+3) - $past(sl(evt_cnt, 4*g+3)))));
  end

  // R3
  rw_union_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl(evt_cnt, E_RW) == CW'(sl(evt_cnt, E_RD) + sl(evt_cnt, E_WR)));

  // R7
  snoop_union_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl(evt_cnt, E_SNP) == CW'(sl(evt_cnt, E_SNP_LOC) + sl(evt_cnt, E_SNP_REM)));

  // R8
  miss_cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sl(evt_cnt, E_DATA_MCYC) - $past(sl(evt_cnt, E_DATA_MCYC))) ==
    CW'($past(|ld_miss_pend)));

  if (SHARED) begin : g_shared
    // R6
    opref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sl(evt_cnt, E_OPREF) == '0);
    // R4
    foreign_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vld && lk_hart != HW'(LOCAL_HART)) |=> $stable(sl(evt_cnt, E_RW)));
  end
endmodule

bind cache_event_tally cache_event_tally_chk #(
  .HW(HW), .LOCAL_HART(LOCAL_HART), .SHARED(SHARED), .NSLOT(NSLOT), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_hart(lk_hart),
  .ld_miss_pend(ld_miss_pend), .evt_cnt(evt_cnt)
);

// File: tb/cache_event_tally_test.sv
`timescale 1ns/1ps
module cache_event_tally_test;
  localparam int HW = 2, ME = 1, NS = 4, CW = 16, NE = 41;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_vld, fill_vld, wb_vld, snp_vld, snp_remote, opf_vld;
  logic [1:0] lk_kind, lk_res, snp_res;
  logic [HW-1:0] lk_hart, fill_hart, wb_hart, snp_hart;
  logic [NS-1:0] ld_miss_pend, code_miss_pend;
  logic [NE*CW-1:0] evt_cnt;

  always #2 clk = ~clk;

  cache_event_tally #(.HW(HW), .LOCAL_HART(ME), .SHARED(1'b1), .NSLOT(NS), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_kind(lk_kind), .lk_hart(lk_hart),
    .lk_res(lk_res), .fill_vld(fill_vld), .fill_hart(fill_hart), .wb_vld(wb_vld),
    .wb_hart(wb_hart), .snp_vld(snp_vld), .snp_hart(snp_hart), .snp_remote(snp_remote),
    .snp_res(snp_res), .opf_vld(opf_vld), .ld_miss_pend(ld_miss_pend),
    .code_miss_pend(code_miss_pend), .evt_cnt(evt_cnt)
  );

  logic [NE-1:0][CW-1:0] mdl = '0;
  logic [NE*CW-1:0] exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;

  task automatic bump(input int i);
    mdl[i] = mdl[i] + 16'd1;
  endtask

  // restated from the requirement text
  task automatic model_cycle();
    int grp, off, soff, org;
    if (lk_vld && lk_hart == ME && lk_res != 2'd3) begin
      case (lk_kind)
        2'd0: grp = 4;
        2'd1: grp = 8;
        2'd2: grp = 12;
        default: grp = 16;
      endcase
      case (lk_res)
        2'd0: off = 1;
        2'd1: off = 2;
        default: off = 3;
      endcase
      bump(grp); bump(grp + off); bump(20); bump(20 + off);
      if (lk_kind != 2'd3) begin bump(0); bump(off); end
    end
    if (fill_vld && fill_hart == ME) bump(26);
    if (wb_vld && wb_hart == ME) bump(27);
    if (snp_vld && snp_hart == ME && snp_res != 2'd3) begin
      soff = (snp_res == 2'd0) ? 3 : (snp_res == 2'd1 ? 1 : 2);
      org = snp_remote ? 37 : 33;
      bump(29); bump(29 + soff); bump(org); bump(org + soff);
    end
    if (ld_miss_pend != 0) bump(24);
    if (code_miss_pend != 0) bump(25);
  endtask

  task automatic quiet();
    lk_vld = 0; lk_kind = 0; lk_hart = ME; lk_res = 0;
    fill_vld = 0; fill_hart = ME; wb_vld = 0; wb_hart = ME;
    snp_vld = 0; snp_hart = ME; snp_remote = 0; snp_res = 0; opf_vld = 0;
    ld_miss_pend = 0; code_miss_pend = 0;
  endtask

  // driver: inputs already set; queue the expectation, then spend the cycle
  task automatic step(input string tag, input bit keep = 0);
    model_cycle();
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
    @(negedge clk);
    if (!keep) quiet();
  endtask

  task automatic lookup(input logic [1:0] k, input logic [1:0] r, input logic [HW-1:0] h, input string tag);
    lk_vld = 1; lk_kind = k; lk_res = r; lk_hart = h;
    step(tag);
  endtask

  task automatic snoop(input logic rem, input logic [1:0] r, input logic [HW-1:0] h, input string tag);
    snp_vld = 1; snp_remote = rem; snp_res = r; snp_hart = h;
    step(tag);
  endtask

  // monitor: compare one expectation after each edge that has one pending
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [NE*CW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (e !== evt_cnt) begin
        fails++;
        for (int i = 0; i < NE; i++)
          if (e[i*CW +: CW] !== evt_cnt[i*CW +: CW]) begin
            $display("FAIL %s counter %0d actual %0d expected %0d", t, i,
                     evt_cnt[i*CW +: CW], e[i*CW +: CW]);
            break;
          end
      end
    end
  end

  initial begin
    #(150000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1 reset zero");
    lookup(2'd0, 2'd0, ME, "R2 load hit");
    lookup(2'd0, 2'd1, ME, "R2 load miss");
    lookup(2'd1, 2'd2, ME, "R3 prefetch merge in read group");
    lookup(2'd2, 2'd0, ME, "R3 code hit in read group");
    lookup(2'd3, 2'd1, ME, "R3 write miss only in rw group");
    lookup(2'd0, 2'd3, ME, "R2 reserved result ignored");
    lookup(2'd0, 2'd1, 2'd0, "R4 foreign hart lookup ignored");
    lookup(2'd3, 2'd0, 2'd3, "R4 foreign hart write ignored");
    fill_vld = 1; fill_hart = ME; step("R5 local fill");
    fill_vld = 1; fill_hart = 2'd2; wb_vld = 1; wb_hart = 2'd0; step("R5 foreign fill wb ignored");
    wb_vld = 1; wb_hart = ME; step("R5 local writeback");
    opf_vld = 1; step("R6 outbound prefetch stays zero");
    snoop(1'b0, 2'd1, ME, "R7 local clean snoop");
    snoop(1'b1, 2'd2, ME, "R7 remote dirty snoop");
    snoop(1'b1, 2'd0, ME, "R7 remote snoop miss");
    snoop(1'b0, 2'd2, 2'd0, "R7 foreign hart snoop ignored");
    snoop(1'b0, 2'd3, ME, "R7 reserved snoop ignored");
    ld_miss_pend = 4'b0011;
    step("R8 two load misses one cycle", 1);
    step("R8 load misses second cycle", 1);
    ld_miss_pend = 4'b1111; code_miss_pend = 4'b0001;
    step("R8 all load slots plus code miss");
    code_miss_pend = 4'b1000; step("R8 code miss alone");
    ld_miss_pend = 4'b0011;
    lk_vld = 1; lk_kind = 2'd0; lk_res = 2'd1; lk_hart = ME;
    fill_vld = 1; fill_hart = ME; wb_vld = 1; wb_hart = ME;
    snp_vld = 1; snp_remote = 1; snp_res = 2'd2; snp_hart = ME; opf_vld = 1;
    step("R9 simultaneous strobes");
    lk_vld = 1; lk_kind = 2'd2; lk_res = 2'd2; lk_hart = ME;
    snp_vld = 1; snp_remote = 0; snp_res = 2'd0; snp_hart = ME;
    step("R9 code merge with local snoop miss");
    code_miss_pend = 4'b0100;
    for (int n = 0; n < 65536; n++) begin
      model_cycle();
      @(negedge clk);
    end
    step("R10 code miss cycle counter wraps");
    step("R1 idle no change");
    @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule